// File: doc/BRIEF.md
# Serial Interrupt Status and Mask

This block gathers the interrupt sources of a two-channel serial unit into one status vector, which software may read, and combines that vector with an 8-bit enable mask to form a single interrupt request. Software can only write the mask, never read it back. Eight sources feed the vector: a change on the input-state pin, a break change on each channel, receiver-ready on each channel, transmitter-ready on each channel, and a clock-ready flag. The logic that creates each source condition sits outside this block.

Two rules set it apart from a plain AND-OR mask. First, a mask write takes effect only while the module-stop input is low. Second, the clock-ready source can never raise the interrupt, whatever value is in its mask position.

Top module: `sio_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the status vector and the interrupt request to 0 and the enable mask to all zeros. After reset, no source raises the request until the mask has been written.
- R2: On every clock edge `status_o` takes the value of `src_i`. The bit positions are 7 input change-of-state, 6 break change B, 5 receiver-ready B, 4 transmitter-ready B, 3 clock-ready, 2 break change A, 1 receiver-ready A and 0 transmitter-ready A.
- R3: `irq_o` is a register. It is 1 one cycle after a cycle in which some status bit other than bit 3 is 1 and its mask bit is 1.
- R4: A status bit whose mask bit is 0 has no effect on `irq_o`.
- R5: The mask does not alter `status_o`. Masked-off sources still read back as set.
- R6: Status bit 3 (clock-ready) never causes `irq_o`, even after a mask write with bit 3 at 1.
- R7: A mask write while `stop_i` is 1 is ignored, and the previous mask stays in force.
- R8: A mask write while `stop_i` is 0 loads `mask_wdata_i` on the edge where `mask_wr_i` is 1. From the next cycle the new mask decides `irq_o`.
- R9: When a mask write and a status change fall on the same edge, the next `irq_o` comes from the new mask combined with the new status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 8 | Raw source status bits |
| stop_i | input | 1 | Module stop; when 1, mask writes are blocked |
| mask_wr_i | input | 1 | Single-cycle write strobe for the mask |
| mask_wdata_i | input | 8 | Mask write data |
| status_o | output | 8 | Registered status vector |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The write to the mask and the sampling of a new status vector can fall on the same clock edge. The bench provokes this by changing `src_i` in the same cycle as a mask write strobe, with the changed source enabled only by the new mask. The bench's reference model must then predict a request on the following cycle and none on the cycle of the write. Blocked writes are judged the same way: a write issued while stopped is followed by a source that only the blocked value would enable, and `irq_o` must stay low.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int SIO_NSRC     = 8;
  localparam int SIO_TXRDY_A  = 0;
  localparam int SIO_RXRDY_A  = 1;
  localparam int SIO_BRKCHG_A = 2;
  localparam int SIO_CLKRDY   = 3;
  localparam int SIO_TXRDY_B  = 4;
  localparam int SIO_RXRDY_B  = 5;
  localparam int SIO_BRKCHG_B = 6;
  localparam int SIO_INCHG    = 7;
  typedef logic [SIO_NSRC-1:0] sio_vec_t;
endpackage

// File: rtl/sio_irq_status.sv
module sio_irq_status #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] status_o
);
  logic [NSRC-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= src_i;
  end

  assign status_o = status_q;

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_o == $past(src_i)); // R2
endmodule

// File: rtl/sio_irq_mask.sv
module sio_irq_mask #(
  parameter int NSRC     = 8,
  parameter int LOCK_IDX = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stop_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] mask_o
);
  logic wr_ok;
  assign wr_ok = wr_i && !stop_i;

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    if (b == LOCK_IDX) begin : g_locked
      assign mask_o[b] = 1'b0;
    end else begin : g_open
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst)        en_q <= 1'b0;
        else if (wr_ok) en_q <= wdata_i[b];
      end
      assign mask_o[b] = en_q;
    end
  end

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_i && stop_i) |=> $stable(mask_o)); // R7
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !stop_i) |=> ((mask_o | (NSRC'(1) << LOCK_IDX)) ==
                           ($past(wdata_i) | (NSRC'(1) << LOCK_IDX)))); // R8
endmodule

// File: rtl/sio_irq_req.sv
module sio_irq_req #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_i & mask_i);
  end

  assign irq_o = irq_q;

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(status_i != '0)); // R4
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int NSRC     = SIO_NSRC,
  parameter int LOCK_IDX = SIO_CLKRDY
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            stop_i,
  input  logic            mask_wr_i,
  input  logic [NSRC-1:0] mask_wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic            irq_o
);
  localparam logic [NSRC-1:0] LOCK_ONLY = NSRC'(1) << LOCK_IDX;

  logic [NSRC-1:0] status_w;
  logic [NSRC-1:0] mask_w;

  sio_irq_status #(.NSRC(NSRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .status_o (status_w)
  );

  sio_irq_mask #(.NSRC(NSRC), .LOCK_IDX(LOCK_IDX)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .stop_i  (stop_i),
    .wr_i    (mask_wr_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_w)
  );

  sio_irq_req #(.NSRC(NSRC)) u_req (
    .clk      (clk),
    .rst      (rst),
    .status_i (status_w),
    .mask_i   (mask_w),
    .irq_o    (irq_o)
  );

  assign status_o = status_w;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (status_o == '0 && !irq_o)); // R1
  AST_CLKRDY_SILENT: assert property (@(posedge clk) disable iff (rst)
    (status_o == LOCK_ONLY) |=> !irq_o); // R6
endmodule

// File: tb/sio_irq_ctrl_bench.sv
module sio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src = '0;
  logic       stop = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] status;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_stat = '0;
  logic [7:0] m_mask = '0;

  always #10 clk = ~clk;

  sio_irq_ctrl u_sio_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .stop_i(stop),
    .mask_wr_i(wr), .mask_wdata_i(wdata),
    .status_o(status), .irq_o(irq)
  );

  // Monitor: compare after every active edge
  always @(posedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      #2;
      e = sb.pop_front();
      tests++;
      if (status !== e.st) begin
        fails++;
        $display("FAIL %s status act=%h exp=%h", e.tag, status, e.st);
      end
      tests++;
      if (irq !== e.irq) begin
        fails++;
        $display("FAIL %s irq act=%b exp=%b", e.tag, irq, e.irq);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push the prediction
  task automatic step(input logic [7:0] s, input logic w, input logic [7:0] d,
                      input logic stp, input string tag);
    exp_t e;
    @(negedge clk);
    src = s; wr = w; wdata = d; stop = stp;
    e.irq = |(m_stat & m_mask & ~8'h08);
    if (w && !stp) m_mask = d;
    m_stat = s;
    e.st  = s;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (status !== 8'h00 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset status=%h irq=%b exp 00/0", status, irq);
    end
    rst = 1'b0;
    // R1: mask reset to zero, nothing raises the request
    step(8'hFF, 0, 8'h00, 0, "R1");
    step(8'hFF, 0, 8'h00, 0, "R1");
    // R8: write full mask, then single source
    step(8'h00, 1, 8'hFF, 0, "R8");
    step(8'h01, 0, 8'h00, 0, "R8");
    step(8'h01, 0, 8'h00, 0, "R3");
    // R6: clock-ready alone with mask bit written 1
    step(8'h08, 0, 8'h00, 0, "R6");
    step(8'h08, 0, 8'h00, 0, "R6");
    step(8'h08, 0, 8'h00, 0, "R6");
    // R2/R3: every bit alone with full mask
    for (int i = 0; i < 8; i++) step(8'(1 << i), 0, 8'h00, 0, "R2");
    step(8'h00, 0, 8'h00, 0, "R3");
    // R4/R5: only bit 4 enabled
    step(8'hFF, 1, 8'h10, 0, "R4");
    step(8'hEF, 0, 8'h00, 0, "R4");
    step(8'hEF, 0, 8'h00, 0, "R5");
    step(8'hEF, 0, 8'h00, 0, "R5");
    // R7: write while stopped is dropped
    step(8'hEF, 1, 8'hFF, 1, "R7");
    step(8'hEF, 0, 8'h00, 0, "R7");
    step(8'hEF, 0, 8'h00, 1, "R7");
    step(8'h10, 0, 8'h00, 1, "R7");
    step(8'h00, 0, 8'h00, 0, "R7");
    // R9: write and new source on the same edge
    step(8'h20, 1, 8'h20, 0, "R9");
    step(8'h00, 0, 8'h00, 0, "R9");
    step(8'h00, 0, 8'h00, 0, "R9");
    // R9: write removing an active source on the same edge
    step(8'h44, 1, 8'h04, 0, "R9");
    step(8'h40, 1, 8'h40, 0, "R9");
    step(8'h04, 1, 8'h08, 0, "R9");
    step(8'h08, 0, 8'h00, 0, "R6");
    step(8'h00, 0, 8'h00, 0, "R6");
    @(negedge clk);
    wr = 1'b0; src = '0;
    repeat (3) @(negedge clk);
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2 scoreboard left=%0d exp=0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule